// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block is the slave side of a serial audio link. It takes the bit clock and the word-select clock from an external source. It receives six channels of playback data on three serial inputs and sends one stereo pair of capture samples on one serial output. A synchronous system clock, much faster than the bit clock, samples the serial clocks. Data moves only on detected bit-clock edges: input bits are taken on the rising edge, and output bits are driven after the falling edge.

A 3-bit format field selects one of six framings:
- right-justified with 24-, 20- or 16-bit words;
- left-justified;
- the one-clock-delayed stereo framing (I2S);
- a single-line mode that carries all six playback channels on the first input.

Received words appear as six 24-bit values. They are updated together once per frame and marked by a one-cycle valid pulse. The capture pair is loaded in parallel at each frame start and shifted out MSB first in the same framing.

Top module: `audio_serial_port`

## Requirements
- R1: Input bits are sampled on rising bit-clock edges, MSB first, two's complement. Word-select low marks the left half and high marks the right half. In the stereo formats, input lane k (k = 0..2) feeds channel 2k from its left half and channel 2k+1 from its right half. Channel n occupies `dac_data[24n+23:24n]`.
- R2: Format codes are: 0 = right-justified 24-bit, 1 = right-justified 20-bit, 2 = right-justified 16-bit, 3 = left-justified, 4 = I2S, 5 = single-line. Codes 6 and 7 are reserved.
- R3: In right-justified formats the word is the last W bits of the half, ending on the bit just before the word-select edge. It is placed at bits 23 down to 24-W of the output, with the bits below cleared.
- R4: In left-justified format the MSB is the first bit after a word-select edge. At most 24 bits are kept. If the half is shorter than 24 bits, the missing low bits read as zero.
- R5: In I2S format the bit at the word-select edge is skipped, and the MSB follows one bit clock later. At most 24 bits are kept.
- R6: In single-line format each half is 64 bit clocks long and holds three 20-bit slots on lane 0 at bit positions 0, 20 and 40. The left half fills channels 0, 2 and 4, the right half fills channels 1, 3 and 5, and the low 4 bits of each word are zero. Lanes 1 and 2 are ignored.
- R7: `dac_valid` is a one-cycle pulse raised on the rising bit-clock edge that starts a left half, once the preceding left and right halves were both received. All six words change in that cycle only.
- R8: While a reserved code is selected, no valid pulse is produced, `dac_data` holds and `sdout` stays 0. After leaving a reserved code, a full left half must be received before the next pulse.
- R9: `adc_left` and `adc_right` are sampled on the falling bit-clock edge where word-select goes low. They are sent MSB first in the selected framing, with `sdout` changing only after falling edges:
  - right-justified: the W MSBs, ending on the last bit of the half, with the half length measured from the previous half;
  - left-justified and I2S: up to 24 bits, aligned as on the input side;
  - single-line: the 20 MSBs in the first 20 bit clocks of each half.
  - Unused bit times are 0.
- R10: During reset `dac_data` is zero, and `dac_valid` and `sdout` are 0.
- R11: Halves of 16, 24, 32 and 64 bit clocks (frames of 32, 48, 64 and 128) are supported in the stereo formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial signals |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt | input | 3 | Framing select (R2) |
| sclk | input | 1 | External bit clock |
| lrck | input | 1 | External word-select clock, low = left |
| sdin | input | 3 | Serial playback data lanes |
| adc_left | input | 24 | Left capture word, loaded at frame start |
| adc_right | input | 24 | Right capture word, loaded at frame start |
| sdout | output | 1 | Serial capture data |
| dac_data | output | 144 | Six received words, channel n at bits 24n+23..24n |
| dac_valid | output | 1 | One-cycle pulse when `dac_data` is updated |

## Verification
The embedded properties assume the following about the inputs:
- both bit-clock phases last at least two system clocks;
- word-select and the data lanes change only together with a falling bit-clock edge;
- the format field changes only at frame boundaries.

The bench drives every bit-clock phase for four system clocks and sets word-select and data at the falling step. It changes the format only with the first falling edge of a frame. The received words are checked on the second of three identical frames, so that the half length the right-justified transmitter measures has settled.

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int DW    = 24,
  parameter int LANES = 3,
  parameter int SLOT  = 20,
  parameter int CW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                fmt,
  input  logic                      sclk,
  input  logic                      lrck,
  input  logic [LANES-1:0]          sdin,
  input  logic [DW-1:0]             adc_left,
  input  logic [DW-1:0]             adc_right,
  output logic                      sdout,
  output logic [2*LANES*DW-1:0]     dac_data,
  output logic                      dac_valid
);
  localparam logic [2:0] F_RJ24 = 3'd0;
  localparam logic [2:0] F_RJ20 = 3'd1;
  localparam logic [2:0] F_RJ16 = 3'd2;
  localparam logic [2:0] F_LJ   = 3'd3;
  localparam logic [2:0] F_I2S  = 3'd4;
  localparam logic [2:0] F_ONE  = 3'd5;
  localparam logic [DW-1:0] TOP = {1'b1, {(DW-1){1'b0}}};

  logic sclk_q;
  logic rise, fall;
  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;

  logic fmt_ok, rj, one;
  assign fmt_ok = (fmt <= F_ONE);
  assign rj     = (fmt <= F_RJ16);
  assign one    = (fmt == F_ONE);

  // receive side
  logic lr_prev, synced, left_done;
  logic [CW-1:0] rcnt;
  logic rx_edge;
  logic [CW-1:0] rpos;
  assign rx_edge = rise && (lrck != lr_prev);
  assign rpos    = rx_edge ? '0 : rcnt;

  logic [LANES-1:0][DW-1:0] acc, stage, fin, oh;
  logic [LANES-1:0]         bitv;
  logic [2*LANES*DW-1:0]    next_data;

  always_comb begin
    int p;
    p = int'(rpos);
    for (int k = 0; k < LANES; k++) begin
      bitv[k] = one ? sdin[0] : sdin[k];
      oh[k] = '0;
      case (fmt)
        F_LJ:  if (p < DW) oh[k] = TOP >> p;
        F_I2S: if (p >= 1 && p <= DW) oh[k] = TOP >> (p - 1);
        F_ONE: if (p >= k*SLOT && p < (k+1)*SLOT) oh[k] = TOP >> (p - k*SLOT);
        default: ;
      endcase
      case (fmt)
        F_RJ20:  fin[k] = acc[k] << (DW - 20);
        F_RJ16:  fin[k] = acc[k] << (DW - 16);
        default: fin[k] = acc[k];
      endcase
      next_data[(2*k)*DW +: DW]   = stage[k];
      next_data[(2*k+1)*DW +: DW] = fin[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= sclk;
      lr_prev   <= 1'b1;
      synced    <= 1'b0;
      left_done <= 1'b0;
      rcnt      <= '0;
      acc       <= '0;
      stage     <= '0;
      dac_data  <= '0;
      dac_valid <= 1'b0;
    end else begin
      sclk_q    <= sclk;
      dac_valid <= 1'b0;
      if (rise) begin
        lr_prev <= lrck;
        if (rx_edge) rcnt <= CW'(1);
        else if (!(&rcnt)) rcnt <= rcnt + 1'b1;
        for (int k = 0; k < LANES; k++) begin
          if (rx_edge)
            acc[k] <= rj ? {{(DW-1){1'b0}}, bitv[k]} : (bitv[k] ? oh[k] : '0);
          else if (rj)
            acc[k] <= {acc[k][DW-2:0], bitv[k]};
          else
            acc[k] <= (acc[k] & ~oh[k]) | (bitv[k] ? oh[k] : '0);
        end
        if (rx_edge) begin
          synced <= 1'b1;
          if (!fmt_ok) begin
            left_done <= 1'b0;
          end else if (synced && !lr_prev) begin
            stage     <= fin;
            left_done <= 1'b1;
          end else if (synced && lr_prev && left_done) begin
            dac_data  <= next_data;
            dac_valid <= 1'b1;
          end
        end
      end
    end
  end

  // transmit side
  logic tx_prev;
  logic [CW-1:0] tcnt, hl;
  logic [DW-1:0] tx_l, tx_r, word;
  logic tx_edge, frame_start, tbit;
  assign tx_edge     = fall && (lrck != tx_prev);
  assign frame_start = tx_edge && !lrck;
  assign word        = frame_start ? adc_left : (lrck ? tx_r : tx_l);

  always_comb begin
    int tp, h, w, idx;
    logic [DW-1:0] m;
    tp = tx_edge ? 0 : int'(tcnt);
    h  = tx_edge ? int'(tcnt) : int'(hl);
    w  = (fmt == F_RJ20) ? 20 : (fmt == F_RJ16) ? 16 : DW;
    idx = tp + w - h;
    m = '0;
    case (fmt)
      F_RJ24, F_RJ20, F_RJ16: if (idx >= 0 && idx < w) m = TOP >> idx;
      F_LJ:  if (tp < DW) m = TOP >> tp;
      F_I2S: if (tp >= 1 && tp <= DW) m = TOP >> (tp - 1);
      F_ONE: if (tp < SLOT) m = TOP >> tp;
      default: ;
    endcase
    tbit = |(word & m);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_prev <= 1'b1;
      tcnt    <= '0;
      hl      <= CW'(32);
      tx_l    <= '0;
      tx_r    <= '0;
      sdout   <= 1'b0;
    end else if (fall) begin
      tx_prev <= lrck;
      sdout   <= tbit;
      if (tx_edge) begin
        tcnt <= CW'(1);
        hl   <= tcnt;
      end else if (!(&tcnt)) begin
        tcnt <= tcnt + 1'b1;
      end
      if (frame_start) begin
        tx_l <= adc_left;
        tx_r <= adc_right;
      end
    end
  end

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> $stable(dac_data));
  assert_valid_left_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> ($past(sclk) && !$past(lrck)));
  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fmt) >= 3'd6) |-> !dac_valid);
  assert_sdout_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall) |-> $stable(sdout));
endmodule

// File: tb/audio_serial_port_tb.sv
module audio_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic sclk = 1'b1;
  logic lrck = 1'b1;
  logic [2:0] sdin = 3'b000;
  logic [23:0] adc_left = '0, adc_right = '0;
  logic sdout;
  logic [143:0] dac_data;
  logic dac_valid;

  int checks = 0, bad = 0, vcount = 0;
  logic [143:0] vdata = '0;

  always #2 clk = ~clk;

  audio_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .sclk(sclk), .lrck(lrck),
    .sdin(sdin), .adc_left(adc_left), .adc_right(adc_right),
    .sdout(sdout), .dac_data(dac_data), .dac_valid(dac_valid));

  always @(negedge clk) if (dac_valid) begin
    vcount++;
    vdata = dac_data;
  end

  typedef struct packed { logic [2:0] f; logic [7:0] hl; logic [7:0] seed; } vec_t;
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'd32, 8'd1}, '{3'd1, 8'd32, 8'd2}, '{3'd2, 8'd16, 8'd3},
    '{3'd0, 8'd24, 8'd4}, '{3'd3, 8'd32, 8'd5}, '{3'd3, 8'd16, 8'd6},
    '{3'd4, 8'd32, 8'd7}, '{3'd4, 8'd64, 8'd8}, '{3'd5, 8'd64, 8'd9},
    '{3'd3, 8'd24, 8'd10}};

  task automatic check(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mkword(input int seed, input int ch);
    logic [31:0] t;
    t = 32'h00A5C35A ^ (seed * 32'h0013579B) ^ (ch * 32'h002468AD) ^ (seed << 20);
    return t[23:0];
  endfunction

  // stereo bit at position pos of a half of length hl
  function automatic logic sbit(input logic [2:0] f, input int hl, input int pos, input logic [23:0] w);
    int width, idx;
    width = (f == 3'd1) ? 20 : (f == 3'd2) ? 16 : 24;
    if (f <= 3'd2) begin
      idx = pos - (hl - width);
      return (idx >= 0 && idx < width) ? w[23-idx] : 1'b0;
    end
    if (f == 3'd3) return (pos < 24) ? w[23-pos] : 1'b0;
    if (f == 3'd4) return (pos >= 1 && pos <= 24) ? w[24-pos] : 1'b0;
    if (f == 3'd5) return (pos < 20) ? w[23-pos] : 1'b0;
    return 1'b0;
  endfunction

  function automatic logic [23:0] expw(input logic [2:0] f, input int hl, input logic [23:0] w);
    int keep;
    case (f)
      3'd0: keep = 24;
      3'd1: keep = 20;
      3'd2: keep = 16;
      3'd3: keep = (hl < 24) ? hl : 24;
      3'd4: keep = (hl - 1 < 24) ? hl - 1 : 24;
      default: keep = 20;
    endcase
    return w & ~(24'hFFFFFF >> keep);
  endfunction

  function automatic string tag(input logic [2:0] f);
    case (f)
      3'd0, 3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // one frame; returns count of sdout bits that differ from expectation
  task automatic run_frame(input logic [2:0] f, input int hl, input logic [5:0][23:0] w,
                           input logic [23:0] al, input logic [23:0] ar, output int miss);
    miss = 0;
    adc_left = al;
    adc_right = ar;
    for (int half = 0; half < 2; half++) begin
      for (int pos = 0; pos < hl; pos++) begin
        logic e;
        @(negedge clk);
        fmt = f;
        sclk = 1'b0;
        lrck = half[0];
        if (f == 3'd5) begin
          int s;
          s = pos / 20;
          sdin[0] = (s < 3) ? w[2*s+half][23-(pos-20*s)] : 1'b0;
          sdin[1] = pos[0] ^ half[0];
          sdin[2] = ~pos[1];
        end else begin
          for (int k = 0; k < 3; k++) sdin[k] = sbit(f, hl, pos, w[2*k+half]);
        end
        repeat (4) @(negedge clk);
        e = (f >= 3'd6) ? 1'b0 : sbit(f, hl, pos, half ? ar : al);
        if (sdout !== e) miss++;
        sclk = 1'b1;
        repeat (3) @(negedge clk);
      end
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [5:0][23:0] w;
    logic [143:0] exp;
    logic [23:0] al, ar;
    int miss, dummy, c0;
    for (int c = 0; c < 6; c++) begin
      w[c] = mkword(v.seed, c);
      exp[24*c +: 24] = expw(v.f, v.hl, w[c]);
    end
    al = mkword(v.seed + 40, 6);
    ar = mkword(v.seed + 40, 7);
    run_frame(v.f, v.hl, w, al, ar, dummy);
    c0 = vcount;
    run_frame(v.f, v.hl, w, al, ar, miss);
    run_frame(v.f, v.hl, w, al, ar, dummy);
    // R1 lane/channel mapping, R2 format code, R11 frame size
    check(vdata === exp, {tag(v.f), " R1 R2 R11 received words"}, vdata, exp);
    check(vcount - c0 == 2, "R7 one pulse per frame", 144'(vcount - c0), 144'd2);
    check(miss == 0, {"R9 sdout framing ", tag(v.f)}, 144'(miss), 144'd0);
  endtask

  initial begin
    int miss, c0;
    logic [143:0] held;
    logic [5:0][23:0] junk;
    repeat (5) @(negedge clk);
    // R10 reset state
    check(dac_data === '0, "R10 data at reset", dac_data, '0);
    check(dac_valid === 1'b0, "R10 valid at reset", 144'(dac_valid), 144'd0);
    check(sdout === 1'b0, "R10 sdout at reset", 144'(sdout), 144'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8 reserved code: no pulse, data held, sdout silent
    for (int c = 0; c < 6; c++) junk[c] = mkword(77, c);
    held = dac_data;
    c0 = vcount;
    run_frame(3'd6, 32, junk, 24'hFFFFFF, 24'hFFFFFF, miss);
    run_frame(3'd7, 32, junk, 24'hFFFFFF, 24'hFFFFFF, miss);
    check(vcount == c0, "R8 no pulse on reserved code", 144'(vcount - c0), 144'd0);
    check(dac_data === held, "R8 data held on reserved code", dac_data, held);
    check(miss == 0, "R8 sdout silent on reserved code", 144'(miss), 144'd0);
    run_vec(VEC[4]);

    // R10 reset in the middle of traffic
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(dac_data === '0, "R10 data after mid-run reset", dac_data, '0);
    check(sdout === 1'b0, "R10 sdout after mid-run reset", 144'(sdout), 144'd0);
    lrck = 1'b1;
    rst_n = 1'b1;
    run_vec(VEC[8]);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule